// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This combinational unit returns the smaller or larger of two floating-point operands. A 4-bit mode input chooses one of sixteen behaviours. The top bit chooses max or min. The next bit chooses whether absolute values are compared first. The low two bits choose how NaNs and signed zeros are treated: an older number-preferring policy, a NaN-propagating policy, a newer number-preferring policy, or a raw compare that always falls through to the second operand.

A precision select picks double precision (all 64 bits) or single precision (the low 32 bits of each operand). Each precision has its own datapath, and the unit returns the one that is selected. The unit also reports a signaling-NaN invalid flag and a summary exception flag. When the record bit is set, it presents both flags in a 4-bit condition field.

Top module: `fp_minmax_unit`

## Requirements
- R1: mode_i[3]=1 selects max and 0 selects min. For two ordinary numbers, the result is the bit pattern of the larger operand (max) or the smaller operand (min).
- R2: mode_i[2]=1 selects magnitude-first. When neither input is NaN and the absolute values differ, the operand with the smaller magnitude (min) or the larger magnitude (max) is returned. Otherwise the base policy in mode_i[1:0] decides.
- R3: mode_i[1:0]=00 is the older number-preferring policy. If exactly one input is a quiet NaN and neither is signaling, the other operand is returned. If any input is signaling, or both are NaN, the result is the canonical NaN.
- R4: mode_i[1:0]=01 is the NaN-propagating policy. Any NaN input gives the canonical NaN.
- R5: mode_i[1:0]=10 is the newer number-preferring policy. A number paired with any NaN (quiet or signaling) is returned. Two NaN inputs give the canonical NaN.
- R6: In the policies 00, 01 and 10, -0.0 orders strictly below +0.0. Min of the two zeros returns -0.0 and max returns +0.0.
- R7: mode_i[1:0]=11 is the raw compare. Min returns A if A<B and B otherwise. Max returns A if A>B and B otherwise. The comparison treats -0.0 and +0.0 as equal, and any NaN returns B unchanged.
- R8: The canonical NaN is 0x7FF8000000000000 in double precision. In single precision it is 0x7FC00000 in the low 32 bits with the upper 32 bits zero.
- R9: vxsnan_o and fx_o are 1 exactly when an input in the selected precision is a signaling NaN. A signaling NaN has an all-ones exponent, a non-zero fraction and the fraction MSB clear.
- R10: With rec_i=1, cr_o = {fx_o, vxsnan_o, 2'b00}. With rec_i=0, cr_o is 0.
- R11: sp_i=1 selects single precision. Only bits [31:0] of each operand are used, and res_o[63:32] is zero. sp_i=0 uses all 64 bits as a double.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| mode_i | input | 4 | {max, magnitude-first, policy[1:0]} |
| rec_i | input | 1 | Record bit, enables cr_o |
| sp_i | input | 1 | 1: single precision, 0: double precision |
| res_o | output | 64 | Selected result |
| vxsnan_o | output | 1 | Signaling-NaN invalid flag |
| fx_o | output | 1 | Summary exception flag |
| cr_o | output | 4 | Condition field, valid when rec_i=1 |

## Verification
The embedded assertions are evaluated on every input change. They check that:
- the result is always operand A, operand B or the canonical NaN;
- any NaN result outside the raw policy is the canonical NaN;
- the raw policy forwards B on NaN;
- the propagating policy never lets a number through a NaN;
- the condition field is zero when not recorded;
- the upper half is zero in single precision.

Choosing the correct operand among ordered values needs the sweep in the bench. This covers signed-zero ordering, magnitude-first fallback, and which of the two number-preferring policies returns a number against a signaling NaN. The sweep runs every mode against all pairs of zeros, infinities, extremes, quiet NaNs and signaling NaNs in both precisions. It checks each result against a model built on real-number comparisons.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int DATA_W = 64;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int N_PREC = 2;

  typedef enum logic [1:0] {
    POL_NUM_OLD  = 2'b00,
    POL_NAN_PROP = 2'b01,
    POL_NUM_NEW  = 2'b10,
    POL_RAW      = 2'b11
  } pol_e;

  typedef struct packed {
    logic sgn;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fcls_t;

  function automatic int prec_exp(input int p);
    return (p == 0) ? DP_EXP : SP_EXP;
  endfunction

  function automatic int prec_man(input int p);
    return (p == 0) ? DP_MAN : SP_MAN;
  endfunction
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  output fcls_t        cls_o,
  output logic [W-2:0] mag_o
);
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;

  assign exp_w = op_i[W-2 -: EXP_W];
  assign man_w = op_i[MAN_W-1:0];
  assign mag_o = op_i[W-2:0];

  always_comb begin
    cls_o.sgn     = op_i[W-1];
    cls_o.is_nan  = (&exp_w) && (|man_w);
    cls_o.is_snan = cls_o.is_nan && !man_w[MAN_W-1];
    cls_o.is_zero = ~|op_i[W-2:0];
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
#(
  parameter int W = 64
) (
  input  fcls_t        cls_a_i,
  input  fcls_t        cls_b_i,
  input  logic [W-2:0] mag_a_i,
  input  logic [W-2:0] mag_b_i,
  output logic         lt_tot_o,
  output logic         gt_tot_o,
  output logic         lt_raw_o,
  output logic         gt_raw_o,
  output logic         mag_lt_o,
  output logic         mag_gt_o
);
  logic nan_any, zero_both;

  assign nan_any   = cls_a_i.is_nan | cls_b_i.is_nan;
  assign zero_both = cls_a_i.is_zero & cls_b_i.is_zero;
  assign mag_lt_o  = mag_a_i < mag_b_i;
  assign mag_gt_o  = mag_a_i > mag_b_i;

  // total order on non-NaN values, -0 below +0
  always_comb begin
    if (cls_a_i.sgn != cls_b_i.sgn) begin
      lt_tot_o = cls_a_i.sgn;
      gt_tot_o = cls_b_i.sgn;
    end else if (!cls_a_i.sgn) begin
      lt_tot_o = mag_lt_o;
      gt_tot_o = mag_gt_o;
    end else begin
      lt_tot_o = mag_gt_o;
      gt_tot_o = mag_lt_o;
    end
  end

  assign lt_raw_o = !nan_any && !zero_both && lt_tot_o;
  assign gt_raw_o = !nan_any && !zero_both && gt_tot_o;

  always_comb begin
    if (lt_raw_o) assert (!gt_raw_o);   // AST_ORDER_EXCL R7
  end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fcls_t        cls_a_i,
  input  fcls_t        cls_b_i,
  input  logic         lt_tot_i,
  input  logic         gt_tot_i,
  input  logic         lt_raw_i,
  input  logic         gt_raw_i,
  input  logic         mag_lt_i,
  input  logic         mag_gt_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic       is_max, use_mag, nan_any, nan_both, snan_any;
  pol_e       pol;
  logic [W-1:0] ordered, base;

  assign is_max   = mode_i[3];
  assign use_mag  = mode_i[2];
  assign pol      = pol_e'(mode_i[1:0]);
  assign nan_any  = cls_a_i.is_nan | cls_b_i.is_nan;
  assign nan_both = cls_a_i.is_nan & cls_b_i.is_nan;
  assign snan_any = cls_a_i.is_snan | cls_b_i.is_snan;
  assign ordered  = (is_max ? gt_tot_i : lt_tot_i) ? a_i : b_i;

  always_comb begin
    unique case (pol)
      POL_NUM_OLD: begin
        if (snan_any || nan_both) base = CANON;
        else if (cls_a_i.is_nan)  base = b_i;
        else if (cls_b_i.is_nan)  base = a_i;
        else                      base = ordered;
      end
      POL_NAN_PROP: base = nan_any ? CANON : ordered;
      POL_NUM_NEW: begin
        if (nan_both)             base = CANON;
        else if (cls_a_i.is_nan)  base = b_i;
        else if (cls_b_i.is_nan)  base = a_i;
        else                      base = ordered;
      end
      default: base = (is_max ? gt_raw_i : lt_raw_i) ? a_i : b_i;
    endcase
  end

  // magnitude-first stage; equal magnitude or NaN falls back
  always_comb begin
    if (use_mag && !nan_any && (mag_lt_i || mag_gt_i))
      res_o = (is_max ? mag_gt_i : mag_lt_i) ? a_i : b_i;
    else
      res_o = base;
  end

  logic res_nan;
  assign res_nan = (&res_o[W-2 -: EXP_W]) && (|res_o[MAN_W-1:0]);

  always_comb begin
    assert (res_o == a_i || res_o == b_i || res_o == CANON);   // AST_RES_SOURCE R1
    if (pol != POL_RAW && res_nan) assert (res_o == CANON);     // AST_NAN_CANON R8
    if (pol == POL_RAW && nan_any) assert (res_o == b_i);       // AST_RAW_NAN_B R7
    if (pol == POL_NAN_PROP && nan_any) assert (res_nan);       // AST_PROP_NAN R4
  end
endmodule

// File: rtl/fmm_core.sv
module fmm_core
  import fmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         snan_o
);
  fcls_t        cls_a, cls_b;
  logic [W-2:0] mag_a, mag_b;
  logic         lt_tot, gt_tot, lt_raw, gt_raw, mag_lt, mag_gt;

  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .op_i(a_i), .cls_o(cls_a), .mag_o(mag_a));
  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .op_i(b_i), .cls_o(cls_b), .mag_o(mag_b));

  fmm_order #(.W(W)) u_order (
    .cls_a_i(cls_a), .cls_b_i(cls_b), .mag_a_i(mag_a), .mag_b_i(mag_b),
    .lt_tot_o(lt_tot), .gt_tot_o(gt_tot), .lt_raw_o(lt_raw), .gt_raw_o(gt_raw),
    .mag_lt_o(mag_lt), .mag_gt_o(mag_gt));

  fmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .mode_i(mode_i), .a_i(a_i), .b_i(b_i), .cls_a_i(cls_a), .cls_b_i(cls_b),
    .lt_tot_i(lt_tot), .gt_tot_i(gt_tot), .lt_raw_i(lt_raw), .gt_raw_i(gt_raw),
    .mag_lt_i(mag_lt), .mag_gt_i(mag_gt), .res_o(res_o));

  assign snan_o = cls_a.is_snan | cls_b.is_snan;
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
(
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic [3:0]  mode_i,
  input  logic        rec_i,
  input  logic        sp_i,
  output logic [63:0] res_o,
  output logic        vxsnan_o,
  output logic        fx_o,
  output logic [3:0]  cr_o
);
  logic [DATA_W-1:0] res_w  [N_PREC];
  logic              snan_w [N_PREC];

  for (genvar p = 0; p < N_PREC; p++) begin : g_prec
    localparam int EW = prec_exp(p);
    localparam int MW = prec_man(p);
    localparam int PW = 1 + EW + MW;
    logic [PW-1:0] res_p;

    fmm_core #(.EXP_W(EW), .MAN_W(MW)) u_core (
      .mode_i(mode_i), .a_i(a_i[PW-1:0]), .b_i(b_i[PW-1:0]),
      .res_o(res_p), .snan_o(snan_w[p]));

    if (PW < DATA_W) begin : g_ext
      assign res_w[p] = {{(DATA_W-PW){1'b0}}, res_p};
    end else begin : g_full
      assign res_w[p] = res_p;
    end
  end

  assign res_o    = sp_i ? res_w[1] : res_w[0];
  assign vxsnan_o = sp_i ? snan_w[1] : snan_w[0];
  assign fx_o     = vxsnan_o;
  assign cr_o     = rec_i ? {fx_o, vxsnan_o, 2'b00} : 4'b0000;

  always_comb begin
    if (!rec_i) assert (cr_o == 4'b0000);          // AST_CR_IDLE R10
    if (sp_i) assert (res_o[63:32] == 32'h0);       // AST_SP_UPPER R11
    assert (fx_o == vxsnan_o);                      // AST_FLAG_SUM R9
  end
endmodule

// File: tb/fp_minmax_unit_tb_top.sv
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic [63:0] a, b, res;
  logic [3:0]  mode, cr;
  logic        rec, sp, vx, fx;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  fp_minmax_unit dut_i (
    .a_i(a), .b_i(b), .mode_i(mode), .rec_i(rec), .sp_i(sp),
    .res_o(res), .vxsnan_o(vx), .fx_o(fx), .cr_o(cr));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] dval(input int i);
    case (i)
      0: return 64'h0000000000000000;  1: return 64'h8000000000000000;
      2: return 64'h3FF0000000000000;  3: return 64'hBFF0000000000000;
      4: return 64'h4000000000000000;  5: return 64'hC004000000000000;
      6: return 64'h7FF0000000000000;  7: return 64'hFFF0000000000000;
      8: return 64'h7FF8000000000000;  9: return 64'h7FF4000000000000;
      10: return 64'hFFF8000000000001; default: return 64'h7FEFFFFFFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] sval(input int i);
    case (i)
      0: return 32'h00000000;  1: return 32'h80000000;
      2: return 32'h3F800000;  3: return 32'hBF800000;
      4: return 32'h40000000;  5: return 32'hC0200000;
      6: return 32'h7F800000;  7: return 32'hFF800000;
      8: return 32'h7FC00000;  9: return 32'h7FA00000;
      10: return 32'hFFC00001; default: return 32'h7F7FFFFF;
    endcase
  endfunction

  function automatic logic [63:0] widen(input logic [31:0] s);
    logic [10:0] e;
    if (s[30:23] == 8'hFF)      e = 11'h7FF;
    else if (s[30:23] == 8'h00) e = 11'h000;
    else                        e = 11'(s[30:23]) + 11'd896;
    return {s[31], e, s[22:0], 29'h0};
  endfunction

  function automatic bit is_nan(input logic [63:0] d);
    return d[62:52] == 11'h7FF && d[51:0] != 0;
  endfunction

  function automatic bit is_snan(input logic [63:0] d);
    return is_nan(d) && !d[51];
  endfunction

  function automatic real absr(input real r);
    return (r < 0.0) ? -r : r;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] ai, input logic [63:0] bi,
                                        input logic [3:0] md, input bit s);
    logic [63:0] da, db, oa, ob, canon, ordered;
    bit na, nb, sn, za, zb, lt, gt, mx;
    real ra, rb;
    da = s ? widen(ai[31:0]) : ai;
    db = s ? widen(bi[31:0]) : bi;
    oa = s ? {32'h0, ai[31:0]} : ai;
    ob = s ? {32'h0, bi[31:0]} : bi;
    canon = s ? 64'h000000007FC00000 : 64'h7FF8000000000000;
    na = is_nan(da); nb = is_nan(db);
    sn = is_snan(da) || is_snan(db);
    za = da[62:0] == 0; zb = db[62:0] == 0;
    mx = md[3];
    ra = $bitstoreal(da); rb = $bitstoreal(db);
    if (md[2] && !na && !nb && absr(ra) != absr(rb))
      return (mx ? absr(ra) > absr(rb) : absr(ra) < absr(rb)) ? oa : ob;
    if (md[1:0] == 2'b11) begin
      if (na || nb) return ob;
      return (mx ? ra > rb : ra < rb) ? oa : ob;
    end
    if (za && zb) begin
      lt = da[63] && !db[63]; gt = !da[63] && db[63];
    end else begin
      lt = ra < rb; gt = ra > rb;
    end
    ordered = (mx ? gt : lt) ? oa : ob;
    case (md[1:0])
      2'b00: begin
        if (sn || (na && nb)) return canon;
        if (na) return ob;
        if (nb) return oa;
        return ordered;
      end
      2'b01: return (na || nb) ? canon : ordered;
      default: begin
        if (na && nb) return canon;
        if (na) return ob;
        if (nb) return oa;
        return ordered;
      end
    endcase
  endfunction

  function automatic string res_tag(input int i, input int j, input logic [3:0] md, input bit s);
    bit nanin = (i >= 8 && i <= 10) || (j >= 8 && j <= 10);
    if (s && i == 2 && j == 4) return "R11";
    if (md[2] && !nanin) return "R2";
    if (md[1:0] == 2'b11) return "R7";
    if (i <= 1 && j <= 1) return "R6";
    if (nanin && i != j) begin
      case (md[1:0])
        2'b00: return "R3";
        2'b01: return "R4";
        default: return "R5";
      endcase
    end
    if (nanin) return "R8";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: mode=%h sp=%0d a=%h b=%h act=%h exp=%h", tag, mode, sp, a, b, act, exp_v);
    end
  endtask

  initial begin
    a = '0; b = '0; mode = '0; rec = 1'b0; sp = 1'b0;
    @(negedge clk);
    chk("R10", {60'h0, cr}, 64'h0);
    chk("R1", res, 64'h0);
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            logic [63:0] er;
            bit esn;
            @(posedge clk); #1;
            mode = 4'(m);
            sp   = p[0];
            rec  = ((i + j) % 2) == 1;
            // single: upper halves carry junk that must be ignored (R11)
            a = p[0] ? {32'hDEAD0000 | 32'(i), sval(i)} : dval(i);
            b = p[0] ? {32'hBEEF0000 | 32'(j), sval(j)} : dval(j);
            @(negedge clk);
            er  = model(a, b, mode, sp);
            esn = (i == 9) || (j == 9);
            chk(res_tag(i, j, mode, sp), res, er);
            chk("R9", {62'h0, vx, fx}, {62'h0, esn, esn});
            chk("R10", {60'h0, cr}, rec ? {60'h0, esn, esn, 2'b00} : 64'h0);
          end
        end
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule